// File: doc/BRIEF.md
# Time-Shared Beam-Break Event Counter

This block counts beam-break events on a bank of light-sensor inputs (64 by default). Instead of an edge detector and a counter for every input, it keeps one datapath and gives each sensor a turn. Every input first passes through its own synchronizer. A capture step then loads all the synchronized levels at once into a parallel-in, serial-out register. That register presents one sensor per clock to a single shared incrementer.

A delay line with one stage per sensor keeps each sensor's level from the previous round. The bit leaving the delay line always belongs to the sensor now being presented. A count is added only when a sensor reads broken now and read clear in the previous round. Counts live in a memory with one word per sensor, and the incrementer does a read-modify-write on that memory. A separate host read port returns the low or high byte of any sensor's count.

A small state machine drives the sequence. After reset it is in SCAN_CLEAR and walks every address, writing zero. On the last address it moves to SCAN_LOAD, a single cycle that captures the sensors. It then moves to SCAN_RUN for one cycle per sensor, with the index counting up from 0. On the last index it returns to SCAN_LOAD, so rounds follow each other with no gap. A synchronous reset from any state returns to SCAN_CLEAR with index 0.

Top module: `sensor_scan_counter`

## Requirements
- R1: While reset is high and on the cycle after it, host_valid is low. Once NUM_SENSORS cycles have passed after reset, every count reads 0.
- R2: When a sensor goes from clear (0) to broken (1) and stays broken for at least NUM_SENSORS+1 cycles, its count rises by exactly one.
- R3: A sensor that stays broken for many rounds adds one count in total. A sensor that stays clear adds none.
- R4: Each sensor's count depends only on that sensor's own input, whatever the other inputs do.
- R5: A round lasts NUM_SENSORS+1 cycles: one SCAN_LOAD cycle, then SCAN_RUN with the index going 0 to NUM_SENSORS-1. The next SCAN_LOAD follows at once. As a result, any level held for NUM_SENSORS+1 cycles is sampled.
- R6: A count is CNT_W bits wide. It wraps from 2^CNT_W-1 to 0 on the next event.
- R7: A cycle with host_rd high selects the sensor on host_addr. On the next cycle host_valid is high and host_data holds a byte of that count: bits 7:0 when host_hi=0, or bits 15:8 when host_hi=1, with the count zero-extended to 16 bits.
- R8: Host reads do not change any count, even when they are repeated while scanning goes on.
- R9: A reset in mid-operation clears all counts and sets every stored previous level to clear. A sensor held broken across the reset therefore counts once afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sensor_in | input | NUM_SENSORS | Raw sensor levels, 1 = beam broken |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | $clog2(NUM_SENSORS) | Sensor to read |
| host_hi | input | 1 | Byte select, 1 = high byte |
| host_data | output | 8 | Selected count byte |
| host_valid | output | 1 | host_data valid, one cycle after host_rd |

## Verification
The default instance is driven by a table of whole-bank patterns: a single sensor, all sensors, all clear, and alternating masks with their complements. These patterns separate the counting of rising edges from the counting of levels, and they would expose crosstalk between neighbouring slots. A long toggle run on one sensor, with each level held for exactly one round, checks that no sample is missed and that the high byte is right. A four-sensor, four-bit instance is toggled until its count wraps, and a reset with a sensor held broken shows that the stored previous levels are cleared.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [1:0] {
        SCAN_CLEAR = 2'd0,
        SCAN_LOAD  = 2'd1,
        SCAN_RUN   = 2'd2
    } scan_state_t;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar s = 0; s < WIDTH; s++) begin : g_chain
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], raw_in[s]};
        end
        assign sync_out[s] = chain[STAGES-1];
    end
endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
    import ssc_pkg::*;
#(
    parameter int NUM_SENSORS = 64,
    localparam int IDX_W = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output scan_state_t      state,
    output logic [IDX_W-1:0] idx,
    output logic             load_en,
    output logic             shift_en,
    output logic             clear_en
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SENSORS - 1);

    scan_state_t      state_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        state_d = state;
        idx_d   = idx;
        unique case (state)
            SCAN_CLEAR: begin
                if (idx == LAST) begin
                    state_d = SCAN_LOAD;
                    idx_d   = '0;
                end else begin
                    idx_d = idx + 1'b1;
                end
            end
            SCAN_LOAD: begin
                state_d = SCAN_RUN;
                idx_d   = '0;
            end
            SCAN_RUN: begin
                if (idx == LAST) begin
                    state_d = SCAN_LOAD;
                    idx_d   = '0;
                end else begin
                    idx_d = idx + 1'b1;
                end
            end
            default: begin
                state_d = SCAN_CLEAR;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SCAN_CLEAR;
            idx   <= '0;
        end else begin
            state <= state_d;
            idx   <= idx_d;
        end
    end

    always_comb begin
        load_en  = 1'b0;
        shift_en = 1'b0;
        clear_en = 1'b0;
        unique case (state)
            SCAN_CLEAR: clear_en = 1'b1;
            SCAN_LOAD:  load_en  = 1'b1;
            SCAN_RUN:   shift_en = 1'b1;
            default:    clear_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/ssc_serializer.sv
module ssc_serializer #(
    parameter int NUM_SENSORS = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_en,
    input  logic                   shift_en,
    input  logic [NUM_SENSORS-1:0] par_in,
    output logic                   cur_level,
    output logic                   prev_level
);
    logic [NUM_SENSORS-1:0] piso_q;
    logic [NUM_SENSORS-1:0] history_q;

    assign cur_level  = piso_q[0];
    assign prev_level = history_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            piso_q    <= '0;
            history_q <= '0;
        end else if (load_en) begin
            piso_q <= par_in;
        end else if (shift_en) begin
            piso_q    <= piso_q >> 1;
            history_q <= {cur_level, history_q[NUM_SENSORS-1:1]};
        end
    end
endmodule

// File: rtl/ssc_count_mem.sv
module ssc_count_mem #(
    parameter int NUM_SENSORS = 64,
    parameter int CNT_W       = 16,
    localparam int IDX_W = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] upd_addr,
    input  logic             upd_clear,
    input  logic             upd_inc,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    input  logic             rd_hi,
    output logic [7:0]       rd_data,
    output logic             rd_valid
);
    logic [CNT_W-1:0] cnt_mem [NUM_SENSORS];
    logic [15:0]      rd_word;

    always_ff @(posedge clk) begin
        if (upd_clear)    cnt_mem[upd_addr] <= '0;
        else if (upd_inc) cnt_mem[upd_addr] <= cnt_mem[upd_addr] + CNT_W'(1);
    end

    assign rd_word = 16'(cnt_mem[rd_addr]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_hi ? rd_word[15:8] : rd_word[7:0];
        end
    end
endmodule

// File: rtl/sensor_scan_counter.sv
module sensor_scan_counter
    import ssc_pkg::*;
#(
    parameter int NUM_SENSORS = 64,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SENSORS-1:0] sensor_in,
    input  logic                   host_rd,
    input  logic [IDX_W-1:0]       host_addr,
    input  logic                   host_hi,
    output logic [7:0]             host_data,
    output logic                   host_valid
);
    logic [NUM_SENSORS-1:0] sensor_sync;
    scan_state_t            seq_state;
    logic [IDX_W-1:0]       seq_idx;
    logic                   load_en, shift_en, clear_en;
    logic                   cur_level, prev_level;
    logic                   event_hit;

    ssc_sync #(.WIDTH(NUM_SENSORS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_in(sensor_in), .sync_out(sensor_sync)
    );

    ssc_sequencer #(.NUM_SENSORS(NUM_SENSORS)) u_seq (
        .clk(clk), .rst(rst), .state(seq_state), .idx(seq_idx),
        .load_en(load_en), .shift_en(shift_en), .clear_en(clear_en)
    );

    ssc_serializer #(.NUM_SENSORS(NUM_SENSORS)) u_ser (
        .clk(clk), .rst(rst), .load_en(load_en), .shift_en(shift_en),
        .par_in(sensor_sync), .cur_level(cur_level), .prev_level(prev_level)
    );

    assign event_hit = shift_en & cur_level & ~prev_level;

    ssc_count_mem #(.NUM_SENSORS(NUM_SENSORS), .CNT_W(CNT_W)) u_mem (
        .clk(clk), .rst(rst), .upd_addr(seq_idx), .upd_clear(clear_en),
        .upd_inc(event_hit), .rd_en(host_rd), .rd_addr(host_addr),
        .rd_hi(host_hi), .rd_data(host_data), .rd_valid(host_valid)
    );
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker
    import ssc_pkg::*;
#(
    parameter int NUM_SENSORS = 64,
    localparam int IDX_W = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1
) (
    input logic             clk,
    input logic             rst,
    input scan_state_t      state,
    input logic [IDX_W-1:0] idx,
    input logic             host_rd,
    input logic             host_valid
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SENSORS - 1);

    // R5
    load_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SCAN_RUN && idx == LAST) |=> state == SCAN_LOAD);

    // R5
    run_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        state == SCAN_LOAD |=> (state == SCAN_RUN && idx == '0));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SCAN_RUN && idx != LAST) |=>
            (state == SCAN_RUN && idx == $past(idx) + 1'b1));

    // R1
    clear_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SCAN_CLEAR && idx != LAST) |=> state == SCAN_CLEAR);

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_valid);
endmodule

bind sensor_scan_counter ssc_checker #(.NUM_SENSORS(NUM_SENSORS)) u_chk (
    .clk(clk), .rst(rst), .state(seq_state), .idx(seq_idx),
    .host_rd(host_rd), .host_valid(host_valid)
);

// File: tb/sensor_scan_counter_bench.sv
`timescale 1ns/1ps
module sensor_scan_counter_bench;
    localparam int N     = 64;
    localparam int ROUND = N + 1;
    localparam int HOLD  = 70;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] sensor_in = '0;
    logic        host_rd = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_hi = 1'b0;
    logic [7:0]  host_data;
    logic        host_valid;

    logic [3:0]  s_sensor = '0;
    logic        s_rd = 1'b0;
    logic [1:0]  s_addr = '0;
    logic        s_hi = 1'b0;
    logic [7:0]  s_data;
    logic        s_valid;

    int tests = 0;
    int fails = 0;
    logic [15:0]  model [N];
    logic [N-1:0] last_pat = '0;

    always #4 clk = ~clk;

    sensor_scan_counter u_sensor_scan_counter (
        .clk(clk), .rst(rst), .sensor_in(sensor_in), .host_rd(host_rd),
        .host_addr(host_addr), .host_hi(host_hi), .host_data(host_data),
        .host_valid(host_valid)
    );

    sensor_scan_counter #(.NUM_SENSORS(4), .CNT_W(4)) u_small (
        .clk(clk), .rst(rst), .sensor_in(s_sensor), .host_rd(s_rd),
        .host_addr(s_addr), .host_hi(s_hi), .host_data(s_data),
        .host_valid(s_valid)
    );

    // {pattern, probe sensor, expected count of probe}
    localparam logic [85:0] VEC [7] = '{
        {64'h0000_0000_0000_0001, 6'd0,  16'd1},
        {64'hFFFF_FFFF_FFFF_FFFF, 6'd0,  16'd1},
        {64'h0000_0000_0000_0000, 6'd63, 16'd1},
        {64'hAAAA_AAAA_AAAA_AAAA, 6'd1,  16'd2},
        {64'h5555_5555_5555_5555, 6'd0,  16'd2},
        {64'hAAAA_AAAA_AAAA_AAAA, 6'd1,  16'd3},
        {64'h8000_0000_0000_0000, 6'd63, 16'd3}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd_byte(input logic [5:0] a, input logic hi, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a; host_hi = hi;
        @(negedge clk);
        host_rd = 1'b0;
        check("R7 valid", {15'd0, host_valid}, 16'd1);
        d = host_data;
    endtask

    task automatic rd_count(input logic [5:0] a, output logic [15:0] c);
        logic [7:0] lo, hi;
        rd_byte(a, 1'b0, lo);
        rd_byte(a, 1'b1, hi);
        c = {hi, lo};
    endtask

    task automatic small_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        s_rd = 1'b1; s_addr = a; s_hi = 1'b0;
        @(negedge clk);
        s_rd = 1'b0;
        d = s_data;
    endtask

    task automatic apply(input logic [N-1:0] pat, input int hold);
        for (int i = 0; i < N; i++)
            if (pat[i] && !last_pat[i]) model[i] = model[i] + 16'd1;
        last_pat = pat;
        @(negedge clk);
        sensor_in = pat;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        logic [15:0] c;
        logic [7:0]  b;
        for (int i = 0; i < N; i++) model[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {15'd0, host_valid}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {15'd0, host_valid}, 16'd0);
        repeat (ROUND) @(negedge clk);
        rd_count(6'd0, c);  check("R1 count 0", c, 16'd0);
        rd_count(6'd63, c); check("R1 count 63", c, 16'd0);

        // R2 R3 R4: pattern table
        for (int v = 0; v < 7; v++) begin
            apply(VEC[v][85:22], HOLD * 2);
            rd_count(VEC[v][21:16], c);
            check("R2/R3 table probe", c, VEC[v][15:0]);
        end
        // R4: every sensor against the model
        for (int i = 0; i < N; i++) begin
            rd_count(6'(i), c);
            check("R4 sweep", c, model[i]);
        end

        // R5: sensor 5 toggled with each level held exactly one round; high byte
        for (int t = 0; t < 300; t++) begin
            apply(last_pat | 64'h20, ROUND);
            apply(last_pat & ~64'h20, ROUND);
        end
        rd_count(6'd5, c);
        check("R5 one-round holds", c, model[5]);
        rd_byte(6'd5, 1'b1, b);
        check("R7 high byte", {8'd0, b}, {8'd0, model[5][15:8]});

        // R8: repeated reads leave counts unchanged
        for (int k = 0; k < 10; k++) begin
            rd_count(6'd1, c);
            check("R8 repeated read", c, model[1]);
        end

        // R6: wrap on the small instance (4-bit counts)
        for (int t = 1; t <= 17; t++) begin
            @(negedge clk); s_sensor = 4'b0001;
            repeat (12) @(negedge clk);
            @(negedge clk); s_sensor = 4'b0000;
            repeat (12) @(negedge clk);
            if (t == 15 || t == 16 || t == 17) begin
                small_rd(2'd0, b);
                check("R6 wrap", {8'd0, b}, (t == 15) ? 16'd15 : (t == 16) ? 16'd0 : 16'd1);
            end
        end
        small_rd(2'd1, b);
        check("R4 small neighbour", {8'd0, b}, 16'd0);

        // R9: reset mid-run with sensor 7 held broken
        @(negedge clk); sensor_in = 64'h80;
        repeat (HOLD * 2) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (ROUND) @(negedge clk);
        rd_count(6'd3, c); check("R9 cleared count", c, 16'd0);
        repeat (HOLD * 2) @(negedge clk);
        rd_count(6'd7, c); check("R9 prev cleared", c, 16'd1);
        repeat (HOLD * 2) @(negedge clk);
        rd_count(6'd7, c); check("R3 held after reset", c, 16'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule